// File: doc/BRIEF.md
# Power-On and Warm Reset Sequencer

This block drives the active-low reset of a processor system bus. It takes an asynchronous power-good level and an asynchronous warm-reset request. The first gives a long cold hold after every power-up. The second gives a short warm hold while power stays good. Both durations are counted in reference clock cycles and set by parameters. Power-good going low forces reset at once, without waiting for a clock edge. Release always happens on a clock edge.

On the edge that releases reset, the block latches the board configuration pins into a strap register. On the same edge it records whether the init input asked for a built-in self-test. After release it reports the boot address, which is a parameter. It also gives a one-cycle pulse to mark the release, and a bus-output enable that turns on one cycle after reset is released. The configuration pins and the init input are treated as quasi-static. They are sampled only on the release edge. There is no data stream, so every pin is a plain control or status level.

Top module: `boot_reset_seq`

## Requirements
- R1: While pwr_ok is low, reset_n, out_en, released, bist_req, strap_q and boot_vec are 0. Each one drops without waiting for a clock edge, and each stays 0 for as long as pwr_ok stays low.
- R2: After pwr_ok rises, it passes through two synchronizer flops. The block then holds reset for COLD_CYCLES cycles. reset_n is first seen high on the (COLD_CYCLES+3)-th rising edge after the rise of pwr_ok.
- R3: A rising edge of warm_req during normal operation passes through two flops. reset_n goes low on the third clock edge after warm_req rises, and stays low for exactly WARM_CYCLES cycles.
- R4: A warm_req rising edge that arrives while reset is already held sets the remaining hold to the larger of the count left and WARM_CYCLES. A cold hold is never shortened by this.
- R5: warm_req acts on its rising edge only. Holding it high after a release does not start another reset.
- R6: strap_q takes the value of cfg_pins present at the release edge. It holds that value unchanged until the next release.
- R7: bist_req takes the value of init_req (1 = run self-test) present at the release edge.
- R8: After a release, boot_vec equals BOOT_VEC (default 32'hFFFF_FFF0), whatever the value of bist_req.
- R9: released is high for exactly one cycle, which is the first cycle in which reset_n is high.
- R10: out_en is never high while reset_n is low. out_en falls on the same edge as reset_n, and rises one cycle after reset_n rises.
- R11: If a warm_req edge takes effect in the cycle in which a hold expires, reset stays asserted for WARM_CYCLES more cycles. No release pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| pwr_ok | input | 1 | Asynchronous power-good level. Low clears the block. |
| warm_req | input | 1 | Asynchronous warm-reset request. Acts on its rising edge. |
| cfg_pins | input | STRAP_W | Configuration pins, sampled at release |
| init_req | input | 1 | Self-test request, sampled at release |
| reset_n | output | 1 | Active-low bus reset |
| out_en | output | 1 | Bus-output enable |
| strap_q | output | STRAP_W | Latched configuration straps |
| bist_req | output | 1 | 1 = self-test selected, 0 = normal boot |
| boot_vec | output | VEC_W | Boot address reported after release |
| released | output | 1 | One-cycle pulse on reset release |

## Verification
A hold counter can expire in the same cycle that a synchronized warm-request edge lands. In that cycle the block must choose between releasing and extending. The bench sweeps the moment it raises warm_req over five cycles around the end of a cold hold, so that the request takes effect two cycles before, exactly on, and two cycles after the expiry. For every offset, reset_n must be low from the third edge after the request through WARM_CYCLES samples. If the block briefly releases at the collision point, the check fails.

// File: rtl/boot_rst_pkg.sv
package boot_rst_pkg;
  typedef enum logic [1:0] {
    ST_OFF       = 2'd0,
    ST_COLD_HOLD = 2'd1,
    ST_WARM_HOLD = 2'd2,
    ST_RUN       = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load,
  input  logic             stretch,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (stretch)         cnt_q <= (load_val > cnt_q) ? load_val : cnt_q;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_TMR_PARK: assert property (@(posedge clk) disable iff (!arst_n)
    (zero && !load && !stretch) |=> zero) else $error("timer left zero"); // R2
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_rst_pkg::*;
#(
  parameter int unsigned COLD_CYCLES = 100000,
  parameter int unsigned WARM_CYCLES = 100,
  parameter int unsigned STRAP_W     = 4,
  parameter int unsigned VEC_W       = 32,
  parameter logic [VEC_W-1:0] BOOT_VEC = 32'hFFFF_FFF0
) (
  input  logic               clk,
  input  logic               pwr_ok,
  input  logic               warm_req,
  input  logic [STRAP_W-1:0] cfg_pins,
  input  logic               init_req,
  output logic               reset_n,
  output logic               out_en,
  output logic [STRAP_W-1:0] strap_q,
  output logic               bist_req,
  output logic [VEC_W-1:0]   boot_vec,
  output logic               released
);
  localparam int unsigned LONGEST = (COLD_CYCLES > WARM_CYCLES) ? COLD_CYCLES : WARM_CYCLES;
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] COLD_LD = CNT_W'(COLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WARM_LD = CNT_W'(WARM_CYCLES - 1);

  logic [1:0]       sync_q;
  logic             pg_s, warm_s, warm_prev, warm_rise;
  logic             tmr_load, tmr_stretch, tmr_zero, release_now;
  logic [CNT_W-1:0] tmr_val;
  seq_state_e       state_q, state_d;

  // Power-good is synchronized by feeding a constant one through flops it clears.
  rs_sync #(.W(2)) u_sync (
    .clk(clk), .arst_n(pwr_ok), .d({warm_req, 1'b1}), .q(sync_q)
  );
  assign pg_s      = sync_q[0];
  assign warm_s    = sync_q[1];
  assign warm_rise = warm_s & ~warm_prev;

  hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .arst_n(pwr_ok), .load(tmr_load), .stretch(tmr_stretch),
    .load_val(tmr_val), .zero(tmr_zero)
  );
  assign tmr_val = (state_q == ST_OFF) ? COLD_LD : WARM_LD;

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_stretch = 1'b0;
    unique case (state_q)
      ST_OFF: if (pg_s) begin
        state_d  = ST_COLD_HOLD;
        tmr_load = 1'b1;
      end
      ST_COLD_HOLD, ST_WARM_HOLD: begin
        if (warm_rise)     tmr_stretch = 1'b1;
        else if (tmr_zero) state_d = ST_RUN;
      end
      ST_RUN: if (warm_rise) begin
        state_d  = ST_WARM_HOLD;
        tmr_load = 1'b1;
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign release_now = (state_q != ST_RUN) && (state_q != ST_OFF) && (state_d == ST_RUN);

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      state_q   <= ST_OFF;
      warm_prev <= 1'b0;
      reset_n   <= 1'b0;
      out_en    <= 1'b0;
      released  <= 1'b0;
      strap_q   <= '0;
      bist_req  <= 1'b0;
      boot_vec  <= '0;
    end else begin
      state_q   <= state_d;
      warm_prev <= warm_s;
      reset_n   <= (state_d == ST_RUN);
      out_en    <= reset_n & (state_d == ST_RUN);
      released  <= release_now;
      if (release_now) begin
        strap_q  <= cfg_pins;
        bist_req <= init_req;
        boot_vec <= BOOT_VEC;
      end
    end
  end

  AST_REL_PULSE: assert property (@(posedge clk) disable iff (!pwr_ok)
    released |-> (reset_n && !$past(reset_n))) else $error("bad release pulse"); // R9
  AST_OE_NEEDS_RST: assert property (@(posedge clk) disable iff (!pwr_ok)
    out_en |-> reset_n) else $error("enable during reset"); // R10
  AST_RELEASE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(reset_n) |-> $past(tmr_zero)) else $error("early release"); // R2
  AST_WARM_ENTRY: assert property (@(posedge clk) disable iff (!pwr_ok)
    (state_q == ST_RUN && warm_rise) |=> (!reset_n && state_q == ST_WARM_HOLD)) else $error("warm entry"); // R3
  AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!pwr_ok)
    ((state_q == ST_COLD_HOLD || state_q == ST_WARM_HOLD) && warm_rise) |=> !reset_n) else $error("collision release"); // R11
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!pwr_ok)
    !released |-> $stable(strap_q)) else $error("strap moved"); // R6
endmodule

// File: tb/boot_reset_seq_test.sv
module boot_reset_seq_test;
  localparam int COLD = 40;
  localparam int WARM = 8;

  logic        clk = 1'b0;
  logic        pwr_ok = 1'b0, warm_req = 1'b0, init_req = 1'b0;
  logic [3:0]  cfg_pins = 4'h0;
  logic        reset_n, out_en, bist_req, released;
  logic [3:0]  strap_q;
  logic [31:0] boot_vec;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  boot_reset_seq #(.COLD_CYCLES(COLD), .WARM_CYCLES(WARM)) uut (
    .clk(clk), .pwr_ok(pwr_ok), .warm_req(warm_req), .cfg_pins(cfg_pins),
    .init_req(init_req), .reset_n(reset_n), .out_en(out_en), .strap_q(strap_q),
    .bist_req(bist_req), .boot_vec(boot_vec), .released(released)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Raise power-good and return the number of negedge samples until reset_n is high.
  task automatic power_up(output int n);
    @(negedge clk); pwr_ok = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!reset_n && n < COLD + 40);
  endtask

  task automatic t_reset_state;
    repeat (5) @(negedge clk);
    chk(reset_n == 0 && out_en == 0 && released == 0, "R1 outputs low while power bad",
        {reset_n, out_en, released}, 0);
    chk(strap_q == 0 && bist_req == 0 && boot_vec == 0, "R1 status cleared", boot_vec, 0);
  endtask

  task automatic t_cold_start;
    int n;
    cfg_pins = 4'hA; init_req = 1'b0;
    power_up(n);
    chk(n == COLD + 3, "R2 cold hold length", n, COLD + 3);
    chk(released == 1 && out_en == 0, "R9/R10 release cycle", {released, out_en}, 2'b10);
    chk(strap_q == 4'hA && bist_req == 0, "R6/R7 straps at cold release", {bist_req, strap_q}, 5'h0A);
    chk(boot_vec == 32'hFFFF_FFF0, "R8 boot vector normal boot", boot_vec, 32'hFFFF_FFF0);
    @(negedge clk);
    chk(released == 0 && out_en == 1, "R9/R10 cycle after release", {released, out_en}, 2'b01);
  endtask

  task automatic t_warm_run;
    int lows;
    @(negedge clk); warm_req = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(reset_n == 1, "R3 no reset before third edge", reset_n, 1);
    @(negedge clk);
    chk(reset_n == 0 && out_en == 0, "R3/R10 reset and enable drop together", {reset_n, out_en}, 0);
    lows = 1;
    while (!reset_n && lows < 4 * WARM) begin
      @(negedge clk);
      if (!reset_n) lows++;
    end
    chk(lows == WARM, "R3 warm hold length", lows, WARM);
    chk(released == 1, "R9 pulse on warm release", released, 1);
  endtask

  task automatic t_warm_level;
    bit stayed = 1'b1;
    repeat (3 * WARM) begin
      @(negedge clk);
      if (!reset_n || released) stayed = 1'b0;
    end
    chk(stayed, "R5 held request does not retrigger", stayed, 1);
    warm_req = 1'b0;
  endtask

  task automatic t_strap_edge;
    logic [3:0] last;
    init_req = 1'b1; last = cfg_pins;
    @(negedge clk); warm_req = 1'b1;
    repeat (3) @(negedge clk);
    while (!reset_n) begin
      last = last + 4'h3; cfg_pins = last;
      @(negedge clk);
    end
    chk(strap_q == last, "R6 straps equal pins at release edge", strap_q, last);
    chk(bist_req == 1, "R7 self-test flagged", bist_req, 1);
    chk(boot_vec == 32'hFFFF_FFF0, "R8 boot vector with self-test", boot_vec, 32'hFFFF_FFF0);
    warm_req = 1'b0; cfg_pins = ~last;
    repeat (4) @(negedge clk);
    chk(strap_q == last, "R6 straps held after release", strap_q, last);
  endtask

  task automatic t_power_drop;
    bit low = 1'b1;
    int n;
    @(negedge clk); warm_req = 1'b1;
    repeat (5) @(negedge clk);
    #1 pwr_ok = 1'b0;
    #0.5;
    chk(reset_n == 0 && out_en == 0 && boot_vec == 0 && bist_req == 0, "R1 immediate clear on power loss",
        {reset_n, out_en, bist_req}, 0);
    warm_req = 1'b0;
    repeat (10) begin @(negedge clk); if (reset_n) low = 1'b0; end
    chk(low, "R1 reset held while power bad", low, 1);
    power_up(n);
    chk(n == COLD + 3, "R2 full cold hold after re-rise", n, COLD + 3);
  endtask

  task automatic t_warm_in_cold;
    int n = 0;
    @(negedge clk); pwr_ok = 1'b0;
    repeat (3) @(negedge clk);
    pwr_ok = 1'b1;
    do begin
      @(negedge clk); n++;
      if (n == 6) warm_req = 1'b1;
      if (n == 9) warm_req = 1'b0;
    end while (!reset_n && n < COLD + 40);
    chk(n >= COLD + 3 && n <= COLD + 4, "R4 warm request does not shorten cold hold", n, COLD + 3);
  endtask

  task automatic t_collision;
    for (int off = 0; off < 5; off++) begin
      int d = COLD - 2 + off;
      bit ok = 1'b1;
      @(negedge clk); pwr_ok = 1'b0; warm_req = 1'b0;
      repeat (3) @(negedge clk);
      pwr_ok = 1'b1;
      for (int j = 1; j <= d + WARM + 6; j++) begin
        @(negedge clk);
        if (j == d) warm_req = 1'b1;
        if (j >= d + 3 && j <= d + 2 + WARM && reset_n) ok = 1'b0;
      end
      warm_req = 1'b0;
      chk(ok, $sformatf("R11 R4 reset held across expiry, offset %0d", off), ok, 1);
    end
  endtask

  initial begin
    t_reset_state;
    t_cold_start;
    t_warm_run;
    t_warm_level;
    t_strap_edge;
    t_power_drop;
    t_warm_in_cold;
    t_collision;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule